// File: doc/BRIEF.md
# Thermal Input Fan-Boost Override

This block sits in the fan path between whatever computes the fan duty cycle (a manual setting or an automatic temperature curve) and the PWM generator. A shared multi-function pin can be assigned one of four roles. When that pin is assigned the thermal role, enabled, and boost is allowed, an external device pulling the pin low forces the fan duty to full scale. The boost lasts only while the pin stays low.

The boost only ever speeds up a fan that is already turning. In manual mode that means the commanded duty is nonzero. In automatic mode it means the measured temperature is above the minimum threshold of the fan curve. When the fan is idle, pulling the pin low changes nothing.

The pin level arrives already synchronised. The qualification is combinational, and the output duty is registered once. The block also decodes the pin-role select into a one-hot indication for the rest of the chip.

Top module: `fan_boost_ovr`

## Requirements
- R1: While `rst_n` is low, `duty_out` is 0x00.
- R2: `role_onehot` is a combinational one-hot decode of `role_sel`: 2'b00 alert output sets bit 0, 2'b01 thermal sets bit 1, 2'b10 general-purpose I/O sets bit 2, 2'b11 tachometer input sets bit 3.
- R3: Boost is active in a cycle when all of these hold: `role_sel`=2'b01, `therm_en`=1, `boost_en`=1, `therm_pin_n`=0, and the fan is running. In the next cycle `duty_out` is 0xFF.
- R4: When `role_sel` is not 2'b01, `therm_pin_n` has no effect, and `duty_out` equals the previous cycle's `duty_in`.
- R5: With `therm_en`=0, `therm_pin_n` has no effect, and `duty_out` follows the previous cycle's `duty_in`.
- R6: With `boost_en`=0, `therm_pin_n` has no effect, and `duty_out` follows the previous cycle's `duty_in`.
- R7: In manual mode (`auto_mode`=0), a `duty_in` of 0x00 suppresses boost, and `duty_out` stays 0x00.
- R8: In automatic mode (`auto_mode`=1), `temp_above_min`=0 suppresses boost for any `duty_in`, and `duty_out` follows `duty_in`.
- R9: In automatic mode, the running test depends only on `temp_above_min`, so boost applies even when `duty_in` is 0x00.
- R10: After the pin is released (`therm_pin_n` returns to 1), `duty_out` returns to the previous cycle's `duty_in` on the next clock.
- R11: Whenever boost is not active, `duty_out` equals the value of `duty_in` one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| role_sel | input | 2 | Function assigned to the shared pin |
| therm_en | input | 1 | Enables the thermal role |
| boost_en | input | 1 | Allows full-speed boost on thermal assertion |
| auto_mode | input | 1 | 1 = automatic curve, 0 = manual duty |
| temp_above_min | input | 1 | Temperature is above the curve minimum |
| duty_in | input | 8 | Computed fan duty |
| therm_pin_n | input | 1 | Synchronised pin level, active low |
| duty_out | output | 8 | Registered duty to the PWM generator |
| role_onehot | output | 4 | Decoded pin role |

## Verification
A wrong qualification term would show up at `duty_out` on the very next clock. It would appear either as a spurious 0xFF while the fan is idle or the pin is assigned another role, or as a missing 0xFF during a valid boost. Because only a single register stands between the inputs and the output, every error becomes visible one cycle after the input pattern that exposes it. The reference model predicts each cycle's duty from the previous cycle's inputs. Directed patterns cover each suppression path and the automatic-mode zero-duty case. Random patterns that favour the thermal role and a low pin level then follow.

// File: rtl/fan_boost_pkg.sv
package fan_boost_pkg;
    localparam int ROLE_W = 2;
    localparam int ROLE_N = 1 << ROLE_W;

    typedef enum logic [ROLE_W-1:0] {
        ROLE_ALERT = 2'b00,
        ROLE_THERM = 2'b01,
        ROLE_GPIO  = 2'b10,
        ROLE_TACH  = 2'b11
    } pin_role_e;
endpackage

// File: rtl/fan_boost_role_dec.sv
module fan_boost_role_dec
    import fan_boost_pkg::*;
#(
    parameter int SEL_W = ROLE_W,
    localparam int OUT_N = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] sel,
    output logic [OUT_N-1:0] onehot
);
    for (genvar g = 0; g < OUT_N; g++) begin : g_dec
        assign onehot[g] = (sel == SEL_W'(g));
    end
endmodule

// File: rtl/fan_boost_qual.sv
module fan_boost_qual
    import fan_boost_pkg::*;
#(
    parameter int DUTY_W = 8
) (
    input  logic              role_is_therm,
    input  logic              therm_en,
    input  logic              boost_en,
    input  logic              auto_mode,
    input  logic              temp_above_min,
    input  logic [DUTY_W-1:0] duty_in,
    input  logic              therm_pin_n,
    output logic              boost_req
);
    logic pin_armed;
    logic fan_running;

    always_comb begin
        pin_armed   = role_is_therm && therm_en && boost_en;
        fan_running = auto_mode ? temp_above_min : (duty_in != '0);
        boost_req   = pin_armed && !therm_pin_n && fan_running;
    end
endmodule

// File: rtl/fan_boost_duty_reg.sv
module fan_boost_duty_reg #(
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boost_req,
    input  logic [DUTY_W-1:0] duty_in,
    output logic [DUTY_W-1:0] duty_q_o
);
    localparam logic [DUTY_W-1:0] FULL_SCALE = '1;

    typedef struct packed {
        logic [DUTY_W-1:0] duty;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.duty = boost_req ? FULL_SCALE : duty_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign duty_q_o = st_q.duty;

    // R3
    boost_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boost_req |=> duty_q_o == FULL_SCALE);
    // R11
    pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !boost_req |=> duty_q_o == $past(duty_in));
endmodule

// File: rtl/fan_boost_ovr.sv
module fan_boost_ovr
    import fan_boost_pkg::*;
#(
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        role_sel,
    input  logic              therm_en,
    input  logic              boost_en,
    input  logic              auto_mode,
    input  logic              temp_above_min,
    input  logic [DUTY_W-1:0] duty_in,
    input  logic              therm_pin_n,
    output logic [DUTY_W-1:0] duty_out,
    output logic [3:0]        role_onehot
);
    logic boost_req;

    fan_boost_role_dec #(.SEL_W(ROLE_W)) u_dec (
        .sel    (role_sel),
        .onehot (role_onehot)
    );

    fan_boost_qual #(.DUTY_W(DUTY_W)) u_qual (
        .role_is_therm  (role_onehot[ROLE_THERM]),
        .therm_en       (therm_en),
        .boost_en       (boost_en),
        .auto_mode      (auto_mode),
        .temp_above_min (temp_above_min),
        .duty_in        (duty_in),
        .therm_pin_n    (therm_pin_n),
        .boost_req      (boost_req)
    );

    fan_boost_duty_reg #(.DUTY_W(DUTY_W)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .boost_req (boost_req),
        .duty_in   (duty_in),
        .duty_q_o  (duty_out)
    );

    // R2
    role_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(role_onehot) == 1 && role_onehot[role_sel]);
    // R4
    role_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        role_sel != ROLE_THERM |=> duty_out == $past(duty_in));
    // R5
    therm_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !therm_en |=> duty_out == $past(duty_in));
    // R6
    boost_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !boost_en |=> duty_out == $past(duty_in));
    // R7
    manual_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_mode && duty_in == '0) |=> duty_out == '0);
    // R8
    auto_cold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_mode && !temp_above_min) |=> duty_out == $past(duty_in));
    // R10
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(therm_pin_n) |=> duty_out == $past(duty_in));
endmodule

// File: tb/sim_fan_boost_ovr.sv
module sim_fan_boost_ovr;
    localparam int CLK_P = 10;

    logic       clk = 0;
    logic       rst_n = 0;
    logic [1:0] role_sel = 2'b00;
    logic       therm_en = 0, boost_en = 0, auto_mode = 0, temp_above_min = 0;
    logic [7:0] duty_in = 8'h00;
    logic       therm_pin_n = 1;
    logic [7:0] duty_out;
    logic [3:0] role_onehot;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    fan_boost_ovr u0 (
        .clk(clk), .rst_n(rst_n), .role_sel(role_sel), .therm_en(therm_en),
        .boost_en(boost_en), .auto_mode(auto_mode), .temp_above_min(temp_above_min),
        .duty_in(duty_in), .therm_pin_n(therm_pin_n),
        .duty_out(duty_out), .role_onehot(role_onehot)
    );

    task automatic chk(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
        end
    endtask

    // Behavioural reference: full scale if every boost condition holds.
    function automatic int model(logic [1:0] rs, logic te, logic be, logic am,
                                 logic ta, logic [7:0] d, logic pn);
        bit run = am ? ta : (d != 0);
        if (rs == 2'b01 && te && be && !pn && run) return 255;
        return d;
    endfunction

    function automatic string tag(logic [1:0] rs, logic te, logic be, logic am,
                                  logic ta, logic [7:0] d, logic pn);
        if (rs != 2'b01) return "R4";
        if (!te) return "R5";
        if (!be) return "R6";
        if (pn) return "R10/R11";
        if (!am && d == 0) return "R7";
        if (am && !ta) return "R8";
        if (am && d == 0) return "R9";
        return "R3";
    endfunction

    // Drive at negedge, check decode at once, check duty one clock later.
    task automatic step(logic [1:0] rs, logic te, logic be, logic am,
                        logic ta, logic [7:0] d, logic pn);
        int exp;
        string t;
        role_sel = rs; therm_en = te; boost_en = be; auto_mode = am;
        temp_above_min = ta; duty_in = d; therm_pin_n = pn;
        #1;
        chk("R2", role_onehot, 1 << rs);
        exp = model(rs, te, be, am, ta, d, pn);
        t = tag(rs, te, be, am, ta, d, pn);
        @(posedge clk);
        @(negedge clk);
        chk(t, duty_out, exp);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        duty_in = 8'h5A;
        repeat (3) @(negedge clk);
        chk("R1", duty_out, 0);
        rst_n = 1;

        // R2: every role code
        for (int r = 0; r < 4; r++) step(2'(r), 0, 0, 0, 0, 8'h10, 1);
        // R3: manual and automatic boost
        step(2'b01, 1, 1, 0, 0, 8'h40, 0);
        step(2'b01, 1, 1, 1, 1, 8'h33, 0);
        // R10: release returns to computed duty
        step(2'b01, 1, 1, 1, 1, 8'h33, 1);
        // R4: other roles ignore a low pin
        step(2'b00, 1, 1, 0, 0, 8'h40, 0);
        step(2'b10, 1, 1, 0, 0, 8'h41, 0);
        step(2'b11, 1, 1, 1, 1, 8'h42, 0);
        // R5 / R6
        step(2'b01, 0, 1, 0, 0, 8'h50, 0);
        step(2'b01, 1, 0, 0, 0, 8'h51, 0);
        // R7: manual, zero duty
        step(2'b01, 1, 1, 0, 1, 8'h00, 0);
        // R8: automatic, below minimum
        step(2'b01, 1, 1, 1, 0, 8'h80, 0);
        step(2'b01, 1, 1, 1, 0, 8'h00, 0);
        // R9: automatic, above minimum, zero duty
        step(2'b01, 1, 1, 1, 1, 8'h00, 0);
        // R11: held pin then release, plus plain pass-through
        step(2'b01, 1, 1, 0, 0, 8'h01, 0);
        step(2'b01, 1, 1, 0, 0, 8'h01, 1);
        step(2'b01, 1, 1, 0, 0, 8'hFE, 1);

        // Random patterns biased toward the thermal role and a low pin
        for (int i = 0; i < 600; i++) begin
            logic [31:0] rv = $urandom;
            logic [1:0] rs = (rv[3:2] != 0) ? 2'b01 : rv[1:0];
            logic [7:0] d  = rv[12] ? 8'h00 : rv[11:4];
            step(rs, rv[13] | rv[14], rv[15] | rv[16], rv[17], rv[18],
                 d, rv[19] & rv[20]);
        end

        // R1: reset during a boost forces zero
        therm_pin_n = 0;
        rst_n = 0;
        @(posedge clk);
        @(negedge clk);
        chk("R1", duty_out, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule